// File: doc/BRIEF.md
# Paged Address Translation Mapper

This block widens a 16-bit CPU address into a 20-bit physical address. The logical space is cut into sixteen 4 KiB pages. The top four logical bits select one of sixteen 8-bit map entries, and that entry supplies the upper eight physical bits. The twelve offset bits pass through unchanged. On its way out, each stored entry has its low four bits inverted. Software must therefore store the wanted physical page XORed with 0x0F.

The map is reprogrammed with ordinary CPU writes to the sixteen addresses at the very top of logical space (0xFFF0 to 0xFFFF). The low nibble of the address picks the entry. This window is decoded from the logical address before translation. Remapping logical page 0xF therefore never hides the map. Such a write still reaches the physical bus, and a flag marks every valid access to the window. A debug port reads any entry back as the raw stored byte. Translation is combinational, and map writes commit on the clock edge.

Top module: `page_mapper`

## Requirements
- R1: paddr_o[11:0] always equals laddr_i[11:0].
- R2: paddr_o[19:12] equals the entry selected by laddr_i[15:12], with its low four bits inverted (stored XOR 0x0F). For example, stored 0x2C gives page 0x23, and stored 0x00 gives page 0x0F.
- R3: A cycle with valid_i=1, we_i=1 and laddr_i in 0xFFF0..0xFFFF stores wdata_i into entry laddr_i[3:0] at that clock edge. Translation from the next cycle uses the new value.
- R4: The table does not change on a write outside the window, on a window access with we_i=0, or on a cycle with valid_i=0.
- R5: Window writes are decoded from the logical address. They update the table whatever physical page logical page 0xF is mapped to.
- R6: While rst_ni is low, entry i holds i XOR 0x0F, so each logical page i maps to physical page i.
- R7: map_hit_o is 1 exactly when valid_i=1 and laddr_i is in 0xFFF0..0xFFFF, for reads and writes alike. During a window write, paddr_o still shows the translation made before the update.
- R8: dbg_data_o returns the raw stored byte of entry dbg_idx_i, before inversion.
- R9: Entries may hold any value, and several logical pages may map to the same physical page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | CPU access valid |
| we_i | input | 1 | CPU write strobe |
| laddr_i | input | 16 | Logical address |
| wdata_i | input | 8 | CPU write data |
| paddr_o | output | 20 | Physical address |
| map_hit_o | output | 1 | Valid access in the map window |
| dbg_idx_i | input | 4 | Debug entry select |
| dbg_data_o | output | 8 | Raw stored byte of selected entry |

## Verification
The bench uses the default parameters: a 4-bit page index, 8-bit entries and an inversion mask of 0x0F. With these values all sixteen entries, both ends of the map window and the address just below it can be reached with a few dozen accesses. The bench remaps logical page 0xF and then writes the map through it. It aliases two logical pages onto one physical page, and it checks the identity mapping both after the first reset and after a reset in mid-run.

// File: rtl/pmap_pkg.sv
package pmap_pkg;
  // entry value that makes logical page idx translate to physical page idx
  function automatic int unsigned pmap_reset_val(int unsigned idx, int unsigned inv_mask);
    return idx ^ inv_mask;
  endfunction
endpackage

// File: rtl/pmap_win_decode.sv
module pmap_win_decode #(
  parameter int unsigned LADDR_W = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic [LADDR_W-1:0] laddr_i,
  output logic               hit_o,
  output logic               wr_en_o,
  output logic [IDX_W-1:0]   idx_o
);
  // window = top 2**IDX_W logical addresses, decoded pre-translation
  assign hit_o   = valid_i && (&laddr_i[LADDR_W-1:IDX_W]);
  assign wr_en_o = hit_o && we_i;
  assign idx_o   = laddr_i[IDX_W-1:0];

  AST_HIT_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> valid_i); // R7
  AST_WR_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (we_i && hit_o)); // R4
endmodule

// File: rtl/pmap_table.sv
module pmap_table
  import pmap_pkg::*;
#(
  parameter int unsigned N_ENT            = 16,
  parameter int unsigned IDX_W            = 4,
  parameter int unsigned ENT_W            = 8,
  parameter logic [ENT_W-1:0] INV_MASK    = 8'h0F
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [ENT_W-1:0]            wr_data_i,
  output logic [N_ENT-1:0][ENT_W-1:0] entries_o
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [ENT_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        ent_q <= ENT_W'(pmap_reset_val(g, int'(INV_MASK)));
      else if (wr_en_i && (wr_idx_i == IDX_W'(g)))
        ent_q <= wr_data_i;
    end
    assign entries_o[g] = ent_q;
  end

  AST_MAP_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> entries_o[$past(wr_idx_i)] == $past(wr_data_i)); // R3
  AST_TABLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(entries_o)); // R4
endmodule

// File: rtl/pmap_rd_mux.sv
module pmap_rd_mux #(
  parameter int unsigned N_ENT = 16,
  parameter int unsigned IDX_W = 4,
  parameter int unsigned ENT_W = 8
) (
  input  logic [N_ENT-1:0][ENT_W-1:0] entries_i,
  input  logic [IDX_W-1:0]            sel_i,
  output logic [ENT_W-1:0]            data_o
);
  assign data_o = entries_i[sel_i];
endmodule

// File: rtl/page_mapper.sv
module page_mapper #(
  parameter int unsigned LADDR_W          = 16,
  parameter int unsigned IDX_W            = 4,
  parameter int unsigned ENT_W            = 8,
  parameter logic [ENT_W-1:0] INV_MASK    = 8'h0F,
  localparam int unsigned N_ENT           = 1 << IDX_W,
  localparam int unsigned OFF_W           = LADDR_W - IDX_W,
  localparam int unsigned PADDR_W         = ENT_W + OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               we_i,
  input  logic [LADDR_W-1:0] laddr_i,
  input  logic [ENT_W-1:0]   wdata_i,
  output logic [PADDR_W-1:0] paddr_o,
  output logic               map_hit_o,
  input  logic [IDX_W-1:0]   dbg_idx_i,
  output logic [ENT_W-1:0]   dbg_data_o
);
  logic                        wr_en;
  logic [IDX_W-1:0]            wr_idx;
  logic [N_ENT-1:0][ENT_W-1:0] entries;
  logic [ENT_W-1:0]            page_raw;

  pmap_win_decode #(.LADDR_W(LADDR_W), .IDX_W(IDX_W)) u_dec (
    .clk_i, .rst_ni, .valid_i, .we_i, .laddr_i,
    .hit_o(map_hit_o), .wr_en_o(wr_en), .idx_o(wr_idx)
  );

  pmap_table #(.N_ENT(N_ENT), .IDX_W(IDX_W), .ENT_W(ENT_W), .INV_MASK(INV_MASK)) u_tbl (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wdata_i),
    .entries_o(entries)
  );

  pmap_rd_mux #(.N_ENT(N_ENT), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_xlate_mux (
    .entries_i(entries), .sel_i(laddr_i[LADDR_W-1:OFF_W]), .data_o(page_raw)
  );

  pmap_rd_mux #(.N_ENT(N_ENT), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_dbg_mux (
    .entries_i(entries), .sel_i(dbg_idx_i), .data_o(dbg_data_o)
  );

  assign paddr_o = {page_raw ^ INV_MASK, laddr_i[OFF_W-1:0]};

  // translation path and debug path must agree on the same entry
  AST_XLATE_MATCHES_DBG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (laddr_i[LADDR_W-1:OFF_W] == dbg_idx_i) |->
      (paddr_o[PADDR_W-1:OFF_W] == (dbg_data_o ^ INV_MASK))); // R2
endmodule

// File: tb/page_mapper_tb_top.sv
module page_mapper_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        we_i = 1'b0;
  logic [15:0] laddr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [19:0] paddr_o;
  logic        map_hit_o;
  logic [3:0]  dbg_idx_i = '0;
  logic [7:0]  dbg_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i; // 125 MHz

  page_mapper dut_i (
    .clk_i, .rst_ni, .valid_i, .we_i, .laddr_i, .wdata_i,
    .paddr_o, .map_hit_o, .dbg_idx_i, .dbg_data_o
  );

  // {we, laddr, wdata, exp_paddr, exp_hit}
  localparam int NV = 16;
  localparam logic [45:0] VEC [NV] = '{
    {1'b0, 16'h0ABC, 8'h00, 20'h00ABC, 1'b0},
    {1'b0, 16'h7123, 8'h00, 20'h07123, 1'b0},
    {1'b0, 16'hF000, 8'h00, 20'h0F000, 1'b0},
    {1'b1, 16'hFFF0, 8'h2C, 20'h0FFF0, 1'b1}, // R3 entry0 <= 0x2C
    {1'b0, 16'h0ABC, 8'h00, 20'h23ABC, 1'b0}, // R2 inversion
    {1'b1, 16'hFFF7, 8'h00, 20'h0FFF7, 1'b1},
    {1'b0, 16'h7FFF, 8'h00, 20'h0FFFF, 1'b0}, // 0x00 -> page 0x0F
    {1'b1, 16'hFFFF, 8'h4C, 20'h0FFFF, 1'b1}, // old page F during write
    {1'b0, 16'hF123, 8'h00, 20'h43123, 1'b0},
    {1'b1, 16'hFFF1, 8'h4C, 20'h43FF1, 1'b1}, // R5 window with F remapped
    {1'b0, 16'h1555, 8'h00, 20'h43555, 1'b0}, // R9 alias
    {1'b0, 16'hF555, 8'h00, 20'h43555, 1'b0}, // R9 alias
    {1'b0, 16'hFFEF, 8'h00, 20'h43FEF, 1'b0}, // just below window
    {1'b1, 16'hFFEF, 8'h99, 20'h43FEF, 1'b0}, // R4 write outside window
    {1'b0, 16'hE000, 8'h00, 20'h0E000, 1'b0}, // R4 entry E untouched
    {1'b0, 16'hF000, 8'h00, 20'h43000, 1'b0}  // R4 entry F untouched
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog all act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R6 reset contents, checked while reset is still held
    for (int i = 0; i < 16; i++) begin
      dbg_idx_i = 4'(i);
      laddr_i = {4'(i), 12'h5A5};
      #1;
      chk("R6 reset raw", 32'(dbg_data_o), 32'(i ^ 8'h0F));
      chk("R6 identity page", 32'(paddr_o), 32'({8'(i), 12'h5A5}));
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // vector table
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      valid_i = 1'b1;
      we_i    = VEC[k][45];
      laddr_i = VEC[k][44:29];
      wdata_i = VEC[k][28:21];
      #1;
      chk("R1 offset", 32'(paddr_o[11:0]), 32'(VEC[k][12:1]));
      chk("R2/R3 page", 32'(paddr_o[19:12]), 32'(VEC[k][20:13]));
      chk("R7 hit", 32'(map_hit_o), 32'(VEC[k][0]));
    end

    // R8 raw readback
    @(negedge clk_i);
    valid_i = 1'b0; we_i = 1'b0;
    dbg_idx_i = 4'h0; #1;
    chk("R8 raw entry0", 32'(dbg_data_o), 32'h2C);
    dbg_idx_i = 4'h7; #1;
    chk("R8 raw entry7", 32'(dbg_data_o), 32'h00);
    dbg_idx_i = 4'h1; #1;
    chk("R8 raw entry1", 32'(dbg_data_o), 32'h4C);

    // R4/R7: strobe without valid
    @(negedge clk_i);
    valid_i = 1'b0; we_i = 1'b1; laddr_i = 16'hFFF2; wdata_i = 8'h11;
    #1;
    chk("R7 no hit w/o valid", 32'(map_hit_o), 32'h0);
    @(negedge clk_i);
    we_i = 1'b0;
    dbg_idx_i = 4'h2; #1;
    chk("R4 invalid write ignored", 32'(dbg_data_o), 32'h0D);

    // R4/R7: read inside window
    @(negedge clk_i);
    valid_i = 1'b1; we_i = 1'b0; laddr_i = 16'hFFF3; wdata_i = 8'h55;
    #1;
    chk("R7 read hit", 32'(map_hit_o), 32'h1);
    @(negedge clk_i);
    valid_i = 1'b0;
    dbg_idx_i = 4'h3; #1;
    chk("R4 window read ignored", 32'(dbg_data_o), 32'h0C);

    // R6 mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    dbg_idx_i = 4'h0; laddr_i = 16'h0ABC;
    #1;
    chk("R6 reset raw entry0", 32'(dbg_data_o), 32'h0F);
    chk("R6 reset identity", 32'(paddr_o), 32'h00ABC);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    summary();
    $finish;
  end
endmodule